// File: doc/BRIEF.md
# Delayed Reset Request Controller

This block turns a watchdog timeout into a system reset that software may postpone but can never cancel. The postponement happens in two stages. The first stage runs on the bus clock: when the watchdog interrupt is enabled, a timeout raises a watchdog interrupt flag and holds the reset request back for a fixed number of bus cycles, which gives software time to react. The request then crosses into a slow low-power clock domain. There the second stage either forces the reset at once, or raises a reset-source interrupt and forces the reset after a selectable grace period.

Once a request exists it is latched, and every later step follows from it. Enables or the delay select may change afterwards, and further timeouts may arrive, without any effect on the outcome. The block's state, including the forced reset output, clears only on the power-on reset input, which is synchronous and active low in both clock domains.

Top module: `reset_postpone_ctrl`

## Requirements
- R1: While `por_n` is low, and after its release until a timeout occurs, `wd_irq_flag`, `rst_src_irq` and `sys_reset` are all 0.
- R2: When a bus edge samples `wd_timeout`=1 with `wd_irq_en`=1, `wd_irq_flag` is 1 after that edge, and the internal reset request rises at the 128th bus edge after it.
- R3: When a bus edge samples `wd_timeout`=1 with `wd_irq_en`=0, `wd_irq_flag` stays 0 and the internal reset request rises at that same edge.
- R4: When the request arrives in the low-power domain with `rst_irq_glob_en`=1 and `rst_irq_wd_en`=1, `rst_src_irq` rises at the arrival edge and `sys_reset` rises exactly D low-power edges later.
- R5: The grace period D follows `dly_sel`, sampled at the arrival edge: 0 gives 10, 1 gives 34, 2 gives 130 and 3 gives 514 low-power cycles.
- R6: When either `rst_irq_glob_en` or `rst_irq_wd_en` is 0 at arrival, `sys_reset` rises at the arrival edge and `rst_src_irq` stays 0.
- R7: After the first timeout, further timeouts and changes to the enables or to `dly_sel` do not change the timing or the values of any output.
- R8: The request crosses domains through a two-flop synchronizer. Arrival is the third low-power rising edge that samples the request level high.
- R9: Without a timeout, nothing is ever asserted. Once asserted, every output stays asserted until `por_n` is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock |
| clk_lp | input | 1 | Slow low-power clock |
| por_n | input | 1 | Power-on reset, synchronous, active low, seen in both domains |
| wd_timeout | input | 1 | Watchdog timeout pulse (bus domain) |
| wd_irq_en | input | 1 | Watchdog interrupt enable; selects the bus-cycle hold |
| rst_irq_glob_en | input | 1 | Global reset-interrupt enable (low-power domain) |
| rst_irq_wd_en | input | 1 | Watchdog-source reset-interrupt enable |
| dly_sel | input | 2 | Grace period select, encoding as in R5 |
| wd_irq_flag | output | 1 | Watchdog interrupt flag (bus domain) |
| rst_src_irq | output | 1 | Reset-source interrupt request (low-power domain) |
| sys_reset | output | 1 | Forced system reset (low-power domain) |

## Verification
The main flow is run with every combination that separates the two stages. The bus-side hold is enabled in some runs and disabled in others, which shows whether the 128-cycle wait belongs to the first stage alone. The second stage runs with both enables set and with each one cleared in turn, which tells the grace path apart from the immediate-force path. All four delay codes are used, so that a mis-decoded table entry shows up as a reset on the wrong low-power edge. One run disturbs the block after the interrupt by changing the enables and the select and by pulsing a second timeout, which exposes any re-sampling or abort. Another run has no timeout at all and confirms that the outputs stay quiet.

// File: rtl/rpc_pkg.sv
// Shared types and the grace-period decode for the delayed reset controller.
// Assumes a 2-bit delay select; the decode is computed, not tabulated.
package rpc_pkg;

    localparam int unsigned DSEL_W = 2;

    typedef enum logic [1:0] {WD_IDLE, WD_HOLD, WD_SENT} wd_state_t;
    typedef enum logic [1:0] {RC_IDLE, RC_GRACE, RC_FORCED} rc_state_t;

    // Grace length in low-power cycles: 2^(2*sel+3)+2 -> 10, 34, 130, 514
    function automatic int unsigned grace_cycles(input logic [DSEL_W-1:0] sel);
        int unsigned s;
        s = int'(sel);
        return (32'd1 << (2 * s + 3)) + 32'd2;
    endfunction

endpackage

// File: rtl/rpc_wd_stage.sv
// Bus-domain stage. On the first timeout after power-on reset it either
// raises the watchdog flag and holds the request for HOLD_CYCLES edges, or
// issues the request at once. The request is a level that stays high until reset.
// Assumes HOLD_CYCLES >= 1 and that later timeouts must be ignored.
module rpc_wd_stage #(
    parameter int unsigned HOLD_CYCLES = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic timeout,
    input  logic irq_en,
    output logic flag,
    output logic req
);
    import rpc_pkg::*;

    localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);

    wd_state_t     state;
    logic [CW-1:0] cnt;

    // Accept the first timeout, run the optional hold, then latch the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WD_IDLE;
            cnt   <= '0;
            flag  <= 1'b0;
            req   <= 1'b0;
        end else begin
            case (state)
                WD_IDLE: begin
                    if (timeout) begin
                        if (irq_en) begin
                            flag  <= 1'b1;
                            cnt   <= CW'(HOLD_CYCLES - 1);
                            state <= WD_HOLD;
                        end else begin
                            req   <= 1'b1;
                            state <= WD_SENT;
                        end
                    end
                end
                WD_HOLD: begin
                    if (cnt == '0) begin
                        req   <= 1'b1;
                        state <= WD_SENT;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rpc_sync.sv
// Multi-flop synchronizer for a level signal entering the destination clock.
// Assumes the source holds the level for many destination cycles.
module rpc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh;

    // Shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], din};
    end

    assign dout = sh[STAGES-1];

endmodule

// File: rtl/rpc_rc_stage.sv
// Low-power-domain stage. When the synchronized request arrives it samples
// the two enables and the delay select once. With both enables set it raises
// the interrupt and forces reset after the grace period; otherwise it forces
// reset at once. All outputs are sticky until reset.
// Assumes MAX_GRACE covers the largest decoded grace length.
module rpc_rc_stage #(
    parameter int unsigned MAX_GRACE = 514
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_in,
    input  logic                      glob_en,
    input  logic                      src_en,
    input  logic [rpc_pkg::DSEL_W-1:0] sel,
    output logic                      irq,
    output logic                      force_rst
);
    import rpc_pkg::*;

    localparam int unsigned CW = $clog2(MAX_GRACE + 1);

    rc_state_t     state;
    logic [CW-1:0] cnt;

    // Decide once on arrival, count the grace period, then force reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RC_IDLE;
            cnt       <= '0;
            irq       <= 1'b0;
            force_rst <= 1'b0;
        end else begin
            case (state)
                RC_IDLE: begin
                    if (req_in) begin
                        if (glob_en && src_en) begin
                            irq   <= 1'b1;
                            cnt   <= CW'(grace_cycles(sel) - 1);
                            state <= RC_GRACE;
                        end else begin
                            force_rst <= 1'b1;
                            state     <= RC_FORCED;
                        end
                    end
                end
                RC_GRACE: begin
                    if (cnt == '0) begin
                        force_rst <= 1'b1;
                        state     <= RC_FORCED;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/reset_postpone_ctrl.sv
// Top of the delayed reset controller: bus-domain hold stage, a two-flop
// crossing of the held request level, and the low-power grace stage.
// Assumes por_n is seen by at least two edges of each clock while low.
module reset_postpone_ctrl #(
    parameter int unsigned WD_HOLD   = 128,
    parameter int unsigned SYNC_LEN  = 2,
    parameter int unsigned MAX_GRACE = 514
) (
    input  logic       clk_bus,
    input  logic       clk_lp,
    input  logic       por_n,
    input  logic       wd_timeout,
    input  logic       wd_irq_en,
    input  logic       rst_irq_glob_en,
    input  logic       rst_irq_wd_en,
    input  logic [1:0] dly_sel,
    output logic       wd_irq_flag,
    output logic       rst_src_irq,
    output logic       sys_reset
);
    logic req_bus;
    logic req_lp;

    rpc_wd_stage #(.HOLD_CYCLES(WD_HOLD)) u_wd (
        .clk     (clk_bus),
        .rst_n   (por_n),
        .timeout (wd_timeout),
        .irq_en  (wd_irq_en),
        .flag    (wd_irq_flag),
        .req     (req_bus)
    );

    rpc_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk   (clk_lp),
        .rst_n (por_n),
        .din   (req_bus),
        .dout  (req_lp)
    );

    rpc_rc_stage #(.MAX_GRACE(MAX_GRACE)) u_rc (
        .clk       (clk_lp),
        .rst_n     (por_n),
        .req_in    (req_lp),
        .glob_en   (rst_irq_glob_en),
        .src_en    (rst_irq_wd_en),
        .sel       (dly_sel),
        .irq       (rst_src_irq),
        .force_rst (sys_reset)
    );

endmodule

// File: rtl/rpc_checker.sv
// Property checker for reset_postpone_ctrl, attached by bind below.
module rpc_checker (
    input logic clk_bus,
    input logic clk_lp,
    input logic por_n,
    input logic wd_irq_en,
    input logic wd_irq_flag,
    input logic rst_src_irq,
    input logic sys_reset,
    input logic req_bus
);
    // R2
    flag_needs_en_chk: assert property (@(posedge clk_bus) disable iff (!por_n)
        $rose(wd_irq_flag) |-> $past(wd_irq_en));

    // R2
    flag_before_req_chk: assert property (@(posedge clk_bus) disable iff (!por_n)
        $rose(wd_irq_flag) |-> !req_bus);

    // R7
    req_sticky_chk: assert property (@(posedge clk_bus) disable iff (!por_n)
        req_bus |=> req_bus);

    // R9
    reset_sticky_chk: assert property (@(posedge clk_lp) disable iff (!por_n)
        sys_reset |=> sys_reset);

    // R9
    irq_sticky_chk: assert property (@(posedge clk_lp) disable iff (!por_n)
        rst_src_irq |=> rst_src_irq);

    // R4
    irq_ahead_of_reset_chk: assert property (@(posedge clk_lp) disable iff (!por_n)
        $rose(rst_src_irq) |-> !sys_reset);

    // R5
    min_grace_chk: assert property (@(posedge clk_lp) disable iff (!por_n)
        ($rose(sys_reset) && rst_src_irq) |-> $past(rst_src_irq, 9));

endmodule

bind reset_postpone_ctrl rpc_checker u_rpc_checker (
    .clk_bus     (clk_bus),
    .clk_lp      (clk_lp),
    .por_n       (por_n),
    .wd_irq_en   (wd_irq_en),
    .wd_irq_flag (wd_irq_flag),
    .rst_src_irq (rst_src_irq),
    .sys_reset   (sys_reset),
    .req_bus     (req_bus)
);

// File: tb/test_reset_postpone_ctrl.sv
module test_reset_postpone_ctrl;

    logic       clk_bus = 1'b0;
    logic       clk_lp  = 1'b0;
    logic       por_n   = 1'b0;
    logic       wd_timeout = 1'b0;
    logic       wd_irq_en = 1'b0;
    logic       rst_irq_glob_en = 1'b0;
    logic       rst_irq_wd_en = 1'b0;
    logic [1:0] dly_sel = 2'd0;
    logic       wd_irq_flag, rst_src_irq, sys_reset;

    int    errors = 0;
    int    checks = 0;
    string cur_tag = "R1";
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;

    // 250 MHz bus clock; low-power clock 8x slower, offset by 1 ns
    always #2 clk_bus = ~clk_bus;
    initial begin
        #1;
        forever #16 clk_lp = ~clk_lp;
    end

    reset_postpone_ctrl i_reset_postpone_ctrl (
        .clk_bus(clk_bus), .clk_lp(clk_lp), .por_n(por_n),
        .wd_timeout(wd_timeout), .wd_irq_en(wd_irq_en),
        .rst_irq_glob_en(rst_irq_glob_en), .rst_irq_wd_en(rst_irq_wd_en),
        .dly_sel(dly_sel), .wd_irq_flag(wd_irq_flag),
        .rst_src_irq(rst_src_irq), .sys_reset(sys_reset)
    );

    // ---------------- behavioural reference model ----------------
    bit m_armed, m_flag, m_req, m_irq, m_rst, m_decided;
    int m_due, m_seen, m_left;

    always @(posedge clk_bus) begin
        if (!por_n) begin
            m_armed = 0; m_flag = 0; m_req = 0; m_due = 0;
        end else if (wd_timeout && !m_armed) begin
            m_armed = 1;
            if (wd_irq_en) begin m_flag = 1; m_due = 128; end
            else m_req = 1;
        end else if (m_due > 0) begin
            m_due = m_due - 1;
            if (m_due == 0) m_req = 1;
        end
    end

    always @(posedge clk_lp) begin
        if (!por_n) begin
            m_seen = 0; m_left = 0; m_irq = 0; m_rst = 0; m_decided = 0;
        end else begin
            if (m_req) m_seen = m_seen + 1;
            if (m_decided && m_left > 0) begin
                m_left = m_left - 1;
                if (m_left == 0) m_rst = 1;
            end else if (!m_decided && m_seen >= 3) begin
                m_decided = 1;
                if (rst_irq_glob_en && rst_irq_wd_en) begin
                    m_irq = 1;
                    case (dly_sel)
                        2'd0: m_left = 10;
                        2'd1: m_left = 34;
                        2'd2: m_left = 130;
                        default: m_left = 514;
                    endcase
                end else begin
                    m_rst = 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // Compare every bus cycle away from both clock edges
    always @(negedge clk_bus) begin
        if (cmp_on && por_n) begin
            chk(cur_tag, "wd_irq_flag", wd_irq_flag, m_flag);
            chk(cur_tag, "rst_src_irq", rst_src_irq, m_irq);
            chk(cur_tag, "sys_reset",   sys_reset,   m_rst);
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_bus);
    endtask

    task automatic do_por();
        @(negedge clk_bus);
        por_n = 1'b0;
        wd_timeout = 1'b0;
        cycles(24);
        chk("R1", "flag in reset", wd_irq_flag, 1'b0);
        chk("R1", "irq in reset",  rst_src_irq, 1'b0);
        chk("R1", "rst in reset",  sys_reset,   1'b0);
    endtask

    task automatic scenario(input string tag, input logic wen, input logic gen,
                            input logic sen, input logic [1:0] sel,
                            input bit meddle, input logic exp_irq);
        do_por();
        cur_tag = tag;
        wd_irq_en = wen; rst_irq_glob_en = gen; rst_irq_wd_en = sen; dly_sel = sel;
        por_n = 1'b1;
        cycles(5);
        wd_timeout = 1'b1;
        cycles(1);
        wd_timeout = 1'b0;
        if (meddle) begin
            for (int i = 0; i < 2000 && !rst_src_irq; i++) cycles(1);
            cycles(3);
            rst_irq_glob_en = 1'b0; rst_irq_wd_en = 1'b0; dly_sel = 2'd0;
            wd_irq_en = ~wen;
            wd_timeout = 1'b1;
            cycles(1);
            wd_timeout = 1'b0;
        end
        for (int i = 0; i < 6000 && !m_rst; i++) cycles(1);
        cycles(100);
        chk(tag, "final sys_reset", sys_reset, 1'b1);
        chk(tag, "final rst_src_irq", rst_src_irq, exp_irq);
        chk(tag, "final wd_irq_flag", wd_irq_flag, wen);
    endtask

    initial begin
        cmp_on = 1'b1;
        // R2 R4 R5 R8: full two-stage path, shortest grace
        scenario("R2 R4 R5 R8", 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1);
        // R3: no bus hold, grace code 1
        scenario("R3 R5", 1'b0, 1'b1, 1'b1, 2'd1, 1'b0, 1'b1);
        // R6: global enable clear
        scenario("R6 glob", 1'b1, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0);
        // R6: source enable clear, no bus hold
        scenario("R6 src", 1'b0, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0);
        // R7: meddling after the interrupt changes nothing, grace code 2
        scenario("R7", 1'b1, 1'b1, 1'b1, 2'd2, 1'b1, 1'b1);
        // R5: longest grace
        scenario("R5 max", 1'b0, 1'b1, 1'b1, 2'd3, 1'b0, 1'b1);
        // R9: outputs stay set, then clear only via power-on reset
        cur_tag = "R9";
        cycles(300);
        chk("R9", "held sys_reset", sys_reset, 1'b1);
        do_por();
        por_n = 1'b1;
        rst_irq_glob_en = 1'b1; rst_irq_wd_en = 1'b1; wd_irq_en = 1'b1;
        cycles(2000);
        chk("R9", "idle sys_reset", sys_reset, 1'b0);
        chk("R9", "idle rst_src_irq", rst_src_irq, 1'b0);
        chk("R9", "idle wd_irq_flag", wd_irq_flag, 1'b0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (190000) @(posedge clk_bus);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule